// File: doc/BRIEF.md
# Selectable-Rate Interpolation Chain

This block sits between a sample source and a DAC core and raises the sample rate by 1, 2, 4 or 8 before the core sees the data. Incoming 14-bit signed words are queued in a small FIFO. A read scheduler takes one word from the FIFO every 2^m core clocks, where m is the mode select. The words then pass through a cascade of three 2x half-band interpolator stages. A multiplexer picks the tap that drives the core: the FIFO output, or the output of stage 1, 2 or 3. The core output is a new sample on every core clock, in every mode.

The first stage runs at the lowest rate and uses the longest filter. The two later stages use a shorter filter. Stages beyond the selected tap are held clear, so they toggle nothing. A change of mode flushes the whole pipeline. The output then stays at mid-scale (two's-complement zero) until fresh data reaches the selected tap. Two one-cycle flags report a word written into a full FIFO, or a scheduled read that finds the FIFO empty. Either one means the source rate does not match the selected ratio. Higher ratios suit higher core update rates: bypass up to about 250 MS/s, 2x up to about 500 MS/s, 4x up to about 800 MS/s, and 8x above that.

Top module: `interp_chain`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the core output is 0 and both flags are low.
- R2: Mode encoding: 0 is bypass, 1 selects the stage 1 output, 2 the stage 2 output and 3 the stage 3 output. The ratio is 2^mode: the FIFO is read once every 2^mode clocks and the output carries one new sample per clock. A source that writes one word every 2^mode clocks raises neither flag while its words last.
- R3: In mode 0 the output reproduces the input words in order.
- R4: Stage 1 turns input x[n] into y[2n] = x[n-2] and y[2n+1] = floor((9*(x[n-1]+x[n-2]) - x[n] - x[n-3]) / 16). The history is zero after a flush.
- R5: Stages 2 and 3 turn input x[n] into y[2n] = x[n-1] and y[2n+1] = floor((x[n-1]+x[n]) / 2). The history is zero after a flush.
- R6: A stage 1 result outside the signed 14-bit range is clamped to +8191 or -8192.
- R7: On the clock where the mode select differs from its previous value, the FIFO and all stages are cleared. The output is 0 on the next clock and stays 0 until new data reaches the tap.
- R8: A write attempted while the FIFO is full is dropped. The overflow flag pulses high for one clock for each such write.
- R9: Once reading has started, a scheduled read that finds the FIFO empty inserts a zero sample and pulses the underflow flag.
- R10: Stages beyond the selected tap stay cleared and issue no samples. The tap output is the cascade truncated at the selected stage.
- R11: After a flush, the read scheduler waits for the first word and raises no underflow before it arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core update clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Interpolation ratio select (0 bypass, 1 2x, 2 4x, 3 8x) |
| in_valid_i | input | 1 | Input word strobe |
| in_data_i | input | 14 | Input word, two's complement |
| core_data_o | output | 14 | Sample to the DAC core, two's complement, one per clock |
| ovf_o | output | 1 | One-clock pulse: write dropped, FIFO full |
| unf_o | output | 1 | One-clock pulse: scheduled read found FIFO empty |

## Verification
The bench streams ramps, an impulse, a constant, a pseudo-random sequence and a full-scale alternating pattern through every mode. It compares the output with an integer model of the truncated cascade, aligned on the first nonzero sample. A wrong tap order or a wrong coefficient shows up as a value mismatch. A missing clamp wraps the full-scale pattern to the opposite sign. A mode switch in mid-stream must give zero on the next clock and keep it there. A design that did not flush would keep leaking old samples. A burst of eight back-to-back writes in 8x mode must give exactly three overflow pulses, so an off-by-one in the full test is caught. The end of each stream must raise underflow, while an idle FIFO after a flush must not.

// File: rtl/interp_pkg.sv
// Shared definitions for the interpolation chain.
// Assumes: mode select is 2 bits, so at most three 2x stages exist.
package interp_pkg;
    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_X2     = 2'd1,
        MODE_X4     = 2'd2,
        MODE_X8     = 2'd3
    } mode_e;

    localparam int NUM_STAGES = 3;
endpackage

// File: rtl/interp_fifo.sv
// Entry FIFO with a rate-paced read scheduler.
// Reads one word each (last+1) clocks once the first word has arrived;
// an empty slot yields a zero sample and an underflow pulse.
// Assumes: clr is a synchronous flush that empties the queue.
module interp_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [2:0]          last,
    input  logic                push,
    input  logic signed [W-1:0] push_data,
    output logic                out_stb,
    output logic signed [W-1:0] out_data,
    output logic                ovf,
    output logic                unf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic signed [W-1:0] mem [DEPTH];
    logic [AW-1:0]       wr_ptr, rd_ptr;
    logic [CW-1:0]       fill;
    logic [2:0]          phase;
    logic                started;
    logic                full, empty, slot, do_pop, do_push;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign slot    = (started || !empty) && (phase == 3'd0);
    assign do_pop  = slot && !empty;
    assign do_push = push && !full;

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= push_data;
    end

    // Pointers, fill level, pacing phase and flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill     <= '0;
            phase    <= '0;
            started  <= 1'b0;
            out_stb  <= 1'b0;
            out_data <= '0;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            fill     <= fill + CW'(do_push) - CW'(do_pop);
            started  <= started || slot;
            phase    <= (started || slot) ? ((phase == last) ? 3'd0 : phase + 3'd1) : 3'd0;
            out_stb  <= slot;
            out_data <= do_pop ? mem[rd_ptr] : '0;
            ovf      <= push && full;
            unf      <= slot && empty;
        end
    end
endmodule

// File: rtl/hb_stage.sv
// One 2x half-band interpolator stage in polyphase form.
// On each input strobe it emits the centre (pass-through) phase; 'half'
// clocks later it emits the filtered mid-point phase.
// LONG=1: 7-tap kernel (-1,0,9,16,9,0,-1)/16 with clamping.
// LONG=0: 3-tap kernel (1,2,1)/2.
// Assumes: input strobes are exactly 2*half clocks apart.
module hb_stage #(
    parameter int W    = 14,
    parameter bit LONG = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [3:0]          half,
    input  logic                in_stb,
    input  logic signed [W-1:0] in_data,
    output logic                out_stb,
    output logic signed [W-1:0] out_data
);
    localparam int NH = LONG ? 4 : 2;
    localparam int AW = W + 6;
    localparam logic signed [AW-1:0] MAXV = AW'((2 ** (W - 1)) - 1);
    localparam logic signed [AW-1:0] MINV = -AW'(2 ** (W - 1));

    logic signed [W-1:0] hist [NH];
    logic signed [W-1:0] even_val, odd_val;
    logic [3:0]          cnt;
    logic                run;

    assign even_val = LONG ? hist[1] : hist[0];

    generate
        if (LONG) begin : g_long
            logic signed [AW-1:0] pair, acc, shf;
            // Mid-point phase of the long kernel, clamped to W bits.
            always_comb begin
                pair = AW'(hist[1]) + AW'(hist[2]);
                acc  = (pair <<< 3) + pair - AW'(hist[0]) - AW'(hist[3]);
                shf  = acc >>> 4;
                if (shf > MAXV)      odd_val = W'(MAXV);
                else if (shf < MINV) odd_val = W'(MINV);
                else                 odd_val = W'(shf);
            end
        end else begin : g_short
            logic signed [AW-1:0] acc;
            // Mid-point phase of the short kernel: floor average.
            always_comb begin
                acc     = AW'(hist[0]) + AW'(hist[1]);
                odd_val = W'(acc >>> 1);
            end
        end
    endgenerate

    // History shift and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NH; i++) hist[i] <= '0;
            cnt      <= '0;
            run      <= 1'b0;
            out_stb  <= 1'b0;
            out_data <= '0;
        end else begin
            out_stb <= 1'b0;
            if (in_stb) begin
                hist[0] <= in_data;
                for (int i = 1; i < NH; i++) hist[i] <= hist[i-1];
                out_data <= even_val;
                out_stb  <= 1'b1;
                cnt      <= 4'd1;
                run      <= 1'b1;
            end else if (run) begin
                cnt <= cnt + 4'd1;
                if (cnt == half) begin
                    out_data <= odd_val;
                    out_stb  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/interp_chain.sv
// Selectable-rate interpolation chain: entry FIFO, three cascaded 2x
// half-band stages, and a tap multiplexer feeding the DAC core.
// Assumes: one core clock; the source writes one word per 2^mode clocks.
module interp_chain #(
    parameter int W          = 14,
    parameter int FIFO_DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic         in_valid_i,
    input  logic [W-1:0] in_data_i,
    output logic [W-1:0] core_data_o,
    output logic         ovf_o,
    output logic         unf_o
);
    import interp_pkg::*;

    logic [1:0]          mode_q;
    logic                flush;
    logic [3:0]          ratio;
    logic [2:0]          last;
    logic                stg_stb [NUM_STAGES + 1];
    logic signed [W-1:0] stg_dat [NUM_STAGES + 1];

    assign flush = (mode_i != mode_q);
    assign ratio = 4'd1 << mode_i;
    assign last  = 3'(ratio - 4'd1);

    // Remember the mode to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_BYPASS;
        else        mode_q <= mode_i;
    end

    interp_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .last      (last),
        .push      (in_valid_i),
        .push_data ($signed(in_data_i)),
        .out_stb   (stg_stb[0]),
        .out_data  (stg_dat[0]),
        .ovf       (ovf_o),
        .unf       (unf_o)
    );

    generate
        for (genvar k = 1; k <= NUM_STAGES; k++) begin : g_stage
            hb_stage #(.W(W), .LONG(k == 1)) u_stg (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (flush || (32'(mode_i) < k)),
                .half     (4'(ratio >> k)),
                .in_stb   (stg_stb[k-1]),
                .in_data  (stg_dat[k-1]),
                .out_stb  (stg_stb[k]),
                .out_data (stg_dat[k])
            );
        end
    endgenerate

    // Register the selected tap towards the core.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) core_data_o <= '0;
        else                 core_data_o <= stg_dat[mode_i];
    end
endmodule

// File: rtl/interp_chain_chk.sv
// Protocol checker for interp_chain, attached by bind.
// Assumes: internal stage strobes are exposed through the bind port list.
module interp_chain_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_i,
    input logic         in_valid_i,
    input logic [W-1:0] core_data_o,
    input logic         ovf_o,
    input logic         unf_o,
    input logic         s2_stb,
    input logic         s3_stb
);
    a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != $past(mode_i)) |=> (core_data_o == '0));

    a_r10_stage2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) < 2'd2) |-> !s2_stb);

    a_r10_stage3_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) < 2'd3) |-> !s3_stb);

    a_r8_ovf_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(in_valid_i));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, unf_o}));
endmodule

bind interp_chain interp_chain_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .in_valid_i  (in_valid_i),
    .core_data_o (core_data_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o),
    .s2_stb      (stg_stb[2]),
    .s3_stb      (stg_stb[3])
);

// File: tb/interp_chain_bench.sv
`timescale 1ns/1ps
module interp_chain_bench;
    localparam int NV   = 11;
    localparam int NIN  = 16;
    localparam int NLEN = 24;
    localparam int VEC_MODE [NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 3, 3, 1};
    localparam int VEC_KIND [NV] = '{0, 4, 0, 2, 1, 4, 1, 2, 0, 3, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        in_valid = 1'b0;
    logic [13:0] in_data = '0;
    logic [13:0] core_data;
    logic        ovf, unf;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int buf_a [512];
    int buf_b [512];
    int cap [512];

    interp_chain u_interp_chain (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_valid_i(in_valid),
        .in_data_i(in_data), .core_data_o(core_data), .ovf_o(ovf), .unf_o(unf)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp14(input int v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic int pattern(input int kind, input int i);
        case (kind)
            0: return 300 * i - 2000;
            1: return (i == 0) ? 3000 : 0;
            2: return ((i / 2) % 2 == 1) ? -8192 : 8191;
            3: return 1234;
            default: return ((i * 7919 + 13) * (i + 3)) % 16384 - 8192;
        endcase
    endfunction

    // Model of one 2x stage: reads buf_a[0..n-1], leaves 2n samples in buf_a.
    task automatic model_stage(input bit lng, input int n);
        for (int i = 0; i < n; i++) begin
            int x0 = buf_a[i];
            int x1 = (i >= 1) ? buf_a[i-1] : 0;
            int x2 = (i >= 2) ? buf_a[i-2] : 0;
            int x3 = (i >= 3) ? buf_a[i-3] : 0;
            if (lng) begin
                buf_b[2*i]   = x2;
                buf_b[2*i+1] = clamp14((9 * (x1 + x2) - x0 - x3) >>> 4);
            end else begin
                buf_b[2*i]   = x1;
                buf_b[2*i+1] = (x0 + x1) >>> 1;
            end
        end
        for (int i = 0; i < 2 * n; i++) buf_a[i] = buf_b[i];
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode = m ^ 2'b01;
        @(negedge clk); mode = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_vector(input int m, input int kind);
        int r = 1 << m;
        int tot = NLEN * r + 40;
        int len = NLEN * r;
        int ei = -1, ai = -1, mism = 0, fa = 0, fe = 0, ovf_n = 0, unf_early = 0, unf_late = 0;
        string req;
        for (int i = 0; i < NLEN; i++) buf_a[i] = (i < NIN) ? pattern(kind, i) : 0;
        for (int s = 1; s <= m; s++) model_stage(s == 1, NLEN << (s - 1));
        set_mode(2'(m));
        for (int c = 0; c < tot; c++) begin
            @(negedge clk);
            cap[c] = int'($signed(core_data));
            if (ovf) ovf_n++;
            if (unf && c < NIN * r) unf_early++;
            if (unf && c > NIN * r + r) unf_late++;
            in_valid = (c % r == 0) && (c / r < NIN);
            in_data  = 14'(pattern(kind, c / r));
        end
        @(negedge clk); in_valid = 1'b0;
        for (int i = 0; i < len; i++) if (ei < 0 && buf_a[i] != 0) ei = i;
        for (int i = 0; i < tot; i++) if (ai < 0 && cap[i] != 0) ai = i;
        req = (m == 0) ? "R3" : (m == 1) ? "R4/R10" : "R5";
        if (kind == 2) req = {req, "/R6"};
        chk(ai >= 0 && ai < 64, {req, " first nonzero sample index"}, ai, ei);
        if (ai >= 0 && ei >= 0) begin
            int ncmp = ((len - ei) < (tot - ai)) ? (len - ei) : (tot - ai);
            for (int i = 0; i < ncmp; i++) begin
                if (cap[ai + i] != buf_a[ei + i]) begin
                    if (mism == 0) begin fa = cap[ai + i]; fe = buf_a[ei + i]; end
                    mism++;
                end
            end
        end
        chk(mism == 0, {req, " output stream"}, fa, fe);
        chk(ovf_n == 0 && unf_early == 0, "R2/R11 no flag at matched rate", ovf_n + unf_early, 0);
        chk(unf_late > 0, "R9 underflow after stream ends", unf_late, 1);
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nz, cnt;
        repeat (4) @(negedge clk);
        chk(core_data == 14'd0 && !ovf && !unf, "R1 reset state", int'(core_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_data == 14'd0 && !ovf && !unf, "R1 first clock after reset", int'(core_data), 0);

        for (int v = 0; v < NV; v++) run_vector(VEC_MODE[v], VEC_KIND[v]);

        // R11: idle after flush gives no underflow
        set_mode(2'd2);
        cnt = 0;
        for (int c = 0; c < 20; c++) begin @(negedge clk); if (unf) cnt++; end
        chk(cnt == 0, "R11 idle FIFO no underflow", cnt, 0);

        // R8: eight back-to-back writes in 8x mode
        set_mode(2'd3);
        cnt = 0;
        for (int c = 0; c < 14; c++) begin
            if (ovf) cnt++;
            in_valid = (c < 8);
            in_data  = 14'(100 + c);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(cnt == 3, "R8 overflow pulse count", cnt, 3);

        // R7: mode switch mid-stream
        set_mode(2'd3);
        for (int c = 0; c < 100; c++) begin
            in_valid = (c % 8 == 0);
            in_data  = 14'd1234;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(core_data != 14'd0, "R7 stream running before switch", int'($signed(core_data)), 1234);
        mode = 2'd2;
        @(negedge clk);
        chk(core_data == 14'd0, "R7 zero on clock after switch", int'($signed(core_data)), 0);
        nz = 0;
        for (int c = 0; c < 12; c++) begin @(negedge clk); if (core_data != 14'd0) nz++; end
        chk(nz == 0, "R7 held at zero until new data", nz, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule